// File: doc/BRIEF.md
# Two-Factor I2C Bit-Rate Divider

This block derives the bit timing of an I2C master from its core clock. One seven-bit divider setting carries two factors. A linear factor M sets a prescaler that wraps every M+1 clocks. An exponent N sets a power-of-two stage that passes on one prescaler wrap out of every 2^(N+1). Each output of the chain is a phase tick. Ten phase ticks make one SCL period, so the bus rate is core_clk / (10 × (M+1) × 2^(N+1)). Software chooses the factors. For the usual 100 kHz target it picks the fastest rate that does not go above the target.

The bit sequencer of the master uses the phase tick and the phase index to place its SDA changes and sample points inside each bit. The block also drives a nominal SCL level: low in the first half of the period and high in the second half. A hold input freezes the whole chain, so a slave that stretches the clock delays the sequence and no phase is lost. A new divider setting is latched only when a period ends, so a period never mixes two rates.

Top module: `i2c_bitclk_div`

## Requirements
- R1: After reset with `enable` low, `phase` is 0, `phase_tick` is 0 and `scl_out` is at its idle level, which is high.
- R2: The exponent N is taken from `div_cfg[2:0]` and the linear factor M from `div_cfg[6:3]`.
- R3: While running and not held, `phase_tick` pulses for one clock exactly once every (M+1) × 2^(N+1) clocks.
- R4: `phase` counts 0 to 9. It advances by one in the clock after each `phase_tick` and goes from 9 back to 0.
- R5: While enabled, `scl_out` is low during phases 0 to 4 and high during phases 5 to 9. Each half lasts 5 × (M+1) × 2^(N+1) clocks, and the full SCL period is 10 × (M+1) × 2^(N+1) clocks.
- R6: A change on `div_cfg` while running has no effect until the tick that ends phase 9. The next period then runs at the new rate.
- R7: While `hold` is high, no `phase_tick` is produced and `phase` and `scl_out` stay constant. After release, the interrupted phase is completed with its remaining clocks only.
- R8: When `enable` is low, all counters are cleared within one clock: `phase` returns to 0 and `scl_out` goes to idle high. The divider setting is then followed directly, so it applies from the first period after `enable` rises.
- R9: The largest setting (M=15, N=7) gives a period of 40960 clocks, and the smallest (M=0, N=0) gives a phase tick every 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the divider chain; low clears it |
| hold | input | 1 | Freezes the chain while a slave stretches SCL |
| div_cfg | input | 7 | Divider setting: N in bits 2:0, M in bits 6:3 |
| phase_tick | output | 1 | One-clock pulse at the end of each phase |
| phase | output | 4 | Current phase index, 0 to 9 |
| scl_out | output | 1 | Nominal SCL level |

## Verification
The bench builds the block with its default parameters: a three-bit exponent, a four-bit linear factor, ten phases and idle-high SCL. With these values the full range of settings can be reached. This includes the smallest divide of 2 clocks per phase and the largest, where one period lasts 40960 clocks and can still be timed within the run. The bench swaps M and N values in separate runs to show which bit field feeds which stage. It changes the setting in the middle of a period and stretches a high phase with `hold`. It times each SCL half and each tick interval against the formula.

// File: rtl/i2c_bitclk_pkg.sv
package i2c_bitclk_pkg;

   // Default field widths of the divider setting
   localparam int unsigned DEF_N_BITS  = 3;
   localparam int unsigned DEF_M_BITS  = 4;
   localparam int unsigned DEF_PHASES  = 10;

   // Terminal count of the power-of-two stage for exponent n: 2^(n+1) - 1
   function automatic int unsigned pow2_last(input int unsigned n);
      return (32'd1 << (n + 1)) - 1;
   endfunction

   // Next value of a modulo counter
   function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned modulus);
      return (v + 1 >= modulus) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/i2c_bitclk_prescale.sv
module i2c_bitclk_prescale #(
   parameter int unsigned M_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              run,
   input  logic [M_BITS-1:0] m_val,
   output logic              pre_tick
);
   logic [M_BITS-1:0] cnt_q;
   logic              at_end;

   assign at_end   = (cnt_q == m_val);
   assign pre_tick = run && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!en)    cnt_q <= '0;
      else if (run)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R3: the linear count never passes the programmed factor
   a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= m_val);

   // R7: a held prescaler keeps its count
   a_r7_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && !$past(run)) |-> $stable(cnt_q));
endmodule

// File: rtl/i2c_bitclk_pow2.sv
module i2c_bitclk_pow2 #(
   parameter int unsigned N_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pre_tick,
   input  logic [N_BITS-1:0] n_val,
   output logic              stage_tick
);
   import i2c_bitclk_pkg::*;

   localparam int unsigned N_MAX = (1 << N_BITS) - 1;
   localparam int unsigned CNT_W = N_MAX + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             at_end;

   assign last       = CNT_W'(pow2_last(32'(n_val)));
   assign at_end     = (cnt_q == last);
   assign stage_tick = pre_tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!en)      cnt_q <= '0;
      else if (pre_tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R3: the exponential count stays below 2^(N+1)
   a_r3_pow_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last);

   // R3: the count only moves on a prescaler wrap
   a_r3_pow_steps: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && !$past(pre_tick)) |-> $stable(cnt_q));
endmodule

// File: rtl/i2c_bitclk_phase.sv
module i2c_bitclk_phase #(
   parameter int unsigned PHASES    = 10,
   parameter bit          IDLE_HIGH = 1'b1,
   localparam int unsigned PH_W     = $clog2(PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            hold,
   input  logic            tick,
   output logic [PH_W-1:0] phase,
   output logic            last_phase,
   output logic            scl
);
   import i2c_bitclk_pkg::*;

   localparam int unsigned HIGH_FROM = PHASES / 2;

   logic [PH_W-1:0] ph_q;
   logic            scl_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ph_q <= '0;
      else if (!en)  ph_q <= '0;
      else if (tick) ph_q <= PH_W'(wrap_inc(32'(ph_q), PHASES));
   end

   assign phase      = ph_q;
   assign last_phase = (ph_q == PH_W'(PHASES - 1));
   assign scl_run    = (ph_q >= PH_W'(HIGH_FROM));

   generate
      if (IDLE_HIGH) begin : g_idle_hi
         assign scl = en ? scl_run : 1'b1;
      end else begin : g_idle_lo
         assign scl = en ? scl_run : 1'b0;
      end
   endgenerate

   // R4: the index stays within the phase count
   a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < PH_W'(PHASES));

   // R4: a tick moves the index on by exactly one, modulo the phase count
   a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && $past(tick)) |->
         (ph_q == (($past(ph_q) == PH_W'(PHASES - 1)) ? '0 : $past(ph_q) + 1'b1)));

   // R7: the phase is frozen while held
   a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && $past(hold)) |-> $stable(ph_q));

   // R8: disabling clears the phase
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (ph_q == '0));
endmodule

// File: rtl/i2c_bitclk_div.sv
module i2c_bitclk_div #(
   parameter int unsigned N_BITS    = i2c_bitclk_pkg::DEF_N_BITS,
   parameter int unsigned M_BITS    = i2c_bitclk_pkg::DEF_M_BITS,
   parameter int unsigned PHASES    = i2c_bitclk_pkg::DEF_PHASES,
   parameter bit          IDLE_HIGH = 1'b1,
   localparam int unsigned CFG_W    = N_BITS + M_BITS,
   localparam int unsigned PH_W     = $clog2(PHASES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             hold,
   input  logic [CFG_W-1:0] div_cfg,
   output logic             phase_tick,
   output logic [PH_W-1:0]  phase,
   output logic             scl_out
);
   generate
      if (N_BITS < 1 || N_BITS > 4) begin : g_bad_n
         $error("N_BITS must be 1 to 4");
      end
      if (M_BITS < 1) begin : g_bad_m
         $error("M_BITS must be at least 1");
      end
      if (PHASES < 2 || (PHASES % 2) != 0) begin : g_bad_ph
         $error("PHASES must be even and at least 2");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_q;
   logic [N_BITS-1:0] n_val;
   logic [M_BITS-1:0] m_val;
   logic              run;
   logic              pre_tick;
   logic              stage_tick;
   logic              last_phase;
   logic              reload;

   assign run    = enable && !hold;
   assign n_val  = cfg_q[N_BITS-1:0];
   assign m_val  = cfg_q[CFG_W-1:N_BITS];
   assign reload = !enable || (stage_tick && last_phase);

   // Setting is taken while idle, or at the tick that closes a period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (reload) cfg_q <= div_cfg;
   end

   i2c_bitclk_prescale #(.M_BITS(M_BITS)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(enable), .run(run),
      .m_val(m_val), .pre_tick(pre_tick));

   i2c_bitclk_pow2 #(.N_BITS(N_BITS)) u_pow (
      .clk(clk), .rst_n(rst_n), .en(enable), .pre_tick(pre_tick),
      .n_val(n_val), .stage_tick(stage_tick));

   i2c_bitclk_phase #(.PHASES(PHASES), .IDLE_HIGH(IDLE_HIGH)) u_ph (
      .clk(clk), .rst_n(rst_n), .en(enable), .hold(hold), .tick(stage_tick),
      .phase(phase), .last_phase(last_phase), .scl(scl_out));

   assign phase_tick = stage_tick;

   // R6: the latched setting only moves at a period boundary while running
   a_r6_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && !($past(stage_tick) && $past(last_phase))) |-> $stable(cfg_q));

   // R7: no tick is issued while held
   a_r7_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !phase_tick);

   // R8: idle SCL level when disabled
   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (scl_out == IDLE_HIGH));
endmodule

// File: tb/sim_i2c_bitclk_div.sv
module sim_i2c_bitclk_div;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       hold = 1'b0;
   logic [6:0] div_cfg = 7'd0;
   logic       phase_tick;
   logic [3:0] phase;
   logic       scl_out;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   i2c_bitclk_div u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold),
      .div_cfg(div_cfg), .phase_tick(phase_tick), .phase(phase), .scl_out(scl_out));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int per(input int m, input int n);
      return (m + 1) << (n + 1);
   endfunction

   // Count negedges until scl_out equals lvl
   task automatic wait_scl(input logic lvl, output int cnt);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (scl_out !== lvl && cnt < 50000);
   endtask

   task automatic start_cfg(input int m, input int n);
      enable = 1'b0;
      div_cfg = {m[3:0], n[2:0]};
      @(negedge clk);
      @(negedge clk);
      enable = 1'b1;
   endtask

   // R2 R5: time a full high and low half
   task automatic t_period(input string req, input int m, input int n);
      int c, hi, lo;
      start_cfg(m, n);
      wait_scl(1'b1, c);
      wait_scl(1'b0, hi);
      wait_scl(1'b1, lo);
      check({req, " high half"}, hi, 5 * per(m, n));
      check({req, " low half"}, lo, 5 * per(m, n));
      check({req, " period"}, hi + lo, 10 * per(m, n));
   endtask

   // R3 R4: tick spacing and phase sequence
   task automatic t_ticks(input int m, input int n);
      int gap;
      logic [3:0] prev;
      start_cfg(m, n);
      do @(negedge clk); while (!phase_tick);
      for (int k = 0; k < 12; k++) begin
         prev = phase;
         gap = 0;
         @(negedge clk);
         check("R4 phase step", phase, (prev == 4'd9) ? 0 : prev + 1);
         gap = 1;
         while (!phase_tick && gap < 5000) begin
            @(negedge clk);
            gap++;
         end
         check("R3 tick spacing", gap, per(m, n));
      end
   endtask

   // R6: setting change mid-period
   task automatic t_change;
      int c, hi, lo;
      start_cfg(1, 0);
      wait_scl(1'b1, c);
      div_cfg = {4'd3, 3'd1};
      wait_scl(1'b0, hi);
      wait_scl(1'b1, lo);
      check("R6 old rate finishes period", hi, 5 * per(1, 0));
      check("R6 new rate next period", lo, 5 * per(3, 1));
   endtask

   // R7: stretch a high phase
   task automatic t_hold;
      int c, cnt;
      logic [3:0] ph0;
      start_cfg(1, 0);
      wait_scl(1'b1, c);
      ph0 = phase;
      hold = 1'b1;
      cnt = 0;
      for (int k = 0; k < 37; k++) begin
         @(negedge clk);
         cnt++;
         if (phase_tick) check("R7 tick while held", 1, 0);
         if (phase !== ph0) check("R7 phase frozen", phase, ph0);
      end
      check("R7 scl held high", scl_out, 1);
      hold = 1'b0;
      while (scl_out !== 1'b0 && cnt < 5000) begin
         @(negedge clk);
         cnt++;
      end
      check("R7 stretched high half", cnt, 5 * per(1, 0) + 37);
   endtask

   // R8: disable clears state
   task automatic t_disable;
      int c;
      start_cfg(0, 1);
      wait_scl(1'b1, c);
      enable = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R8 phase cleared", phase, 0);
      check("R8 scl idle high", scl_out, 1);
      check("R8 no tick", phase_tick, 0);
   endtask

   initial begin : wd
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset phase", phase, 0);
      check("R1 reset tick", phase_tick, 0);
      check("R1 reset scl idle", scl_out, 1);
      t_period("R2 M=2 N=0", 2, 0);
      t_period("R2 M=0 N=2", 0, 2);
      t_period("R5 M=5 N=3", 5, 3);
      t_ticks(4, 1);
      t_ticks(0, 0);
      t_change();
      t_hold();
      t_disable();
      t_period("R9 M=15 N=7", 15, 7);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule